// File: doc/BRIEF.md
# DRAM Strobe-Sequence Cycle Decoder

This block sits beside an EDO DRAM interface and watches the row strobe, column strobe, write enable, output enable and the multiplexed address bus. It samples these active-low strobes on a fast system clock. From the order in which their edges arrive, it works out what kind of cycle each row-strobe period was. The possible kinds are:

- a read
- an early write
- a read-modify-write
- a refresh of a row taken from the address bus
- a refresh with the column strobe leading
- a hidden refresh
- a self refresh
- a test-mode entry

When the row strobe rises, the decoder emits a one-clock report. The report carries the cycle kind and the row that was opened or refreshed.

The block keeps its own copy of the device's internal refresh row counter. The counter advances only on refresh cycles where the column strobe leads. This lets a bus monitor or checker know which row such a refresh touched. The block also tracks when the device would drive its data pins, so a monitor can detect bus contention. A write enable that falls too soon after the column strobe cannot be classified safely, so the decoder reports it as an indeterminate cycle instead of guessing. It stores no data and measures no analog timing.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After a synchronous reset, `cyc_valid` and `dq_oe` are 0, `cyc_type` is 0 (none), `cyc_row` is 0 and the internal refresh row counter is 0.
- R2: Exactly one report pulse occurs per row-strobe period. `cyc_valid` is high for one clock, on the clock after the sample in which `ras_n` is first seen high after being low. `cyc_type` is 0 whenever `cyc_valid` is low.
- R3: A row-strobe period in which the column strobe never falls is reported as type 4 (row refresh). `cyc_row` equals `addr` as sampled when `ras_n` was first seen low.
- R4: If `cas_n` was already low in the sample before `ras_n` is first seen low, the period is a column-leading refresh, reported as type 5. `cyc_row` is the counter value, and the counter then increments, wrapping at 2^ROW_BITS. If both strobes fall in the same sample, the column strobe counts as later, and the period is an access.
- R5: If the column strobe fell during an access and stays low while the row strobe rises and falls again, the next period is a hidden refresh, reported as type 6. `cyc_row` is the counter value and the counter increments. `dq_oe` stays high across it.
- R6: If `we_n` is low in the sample where the column strobe falls during an access, including when both fall in the same sample, that column access is an early write (type 2). `dq_oe` stays 0 after it.
- R7: If `we_n` falls while the column strobe is low during an access, at least RMW_MIN samples after the column strobe fell, that access is a read-modify-write (type 3).
- R8: If `we_n` falls fewer than RMW_MIN samples after the column strobe fell, that access is indeterminate (type 9).
- R9: A column-leading refresh with `we_n` low when the row strobe falls is a test-mode entry (type 8). `cyc_row` is the counter value, and the counter does not advance.
- R10: A column-leading refresh whose row strobe stays low for at least SELF_MIN samples is a self refresh (type 7), and the counter advances by one. One sample fewer yields type 5.
- R11: A column strobe falling with `we_n` high during an access is a read (type 1). From the clock after that sample, `dq_oe` follows the sampled `oe_n` inverted. The read data stays valid while either strobe is low and is released on the clock after both strobes are sampled high.
- R12: With several column accesses in one row-strobe period, the reported type takes the highest-ranked kind seen: indeterminate, then read-modify-write, then early write, then read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row address strobe, active low |
| cas_n | input | 1 | Column address strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_BITS | Multiplexed address bus |
| cyc_valid | output | 1 | One-clock pulse when a row-strobe period ends |
| cyc_type | output | 4 | Cycle kind code (see requirements) |
| cyc_row | output | ROW_BITS | Row opened or refreshed by the reported period |
| dq_oe | output | 1 | High while the device would drive its data pins |

## Verification
On every clock, the embedded properties check four things:

- the report pulse lasts one clock and follows a sampled row-strobe rise;
- the refresh counter steps by exactly one when it advances and holds during a test-mode entry;
- the data-drive flag drops after both strobes are seen high;
- an early write never leaves the data pins driven.

The classification itself depends on whole edge sequences, so only the bench scenarios can show it. These scenarios cover:

- same-sample ties between strobes;
- the boundary at RMW_MIN between read-modify-write and indeterminate;
- the boundary at SELF_MIN between self refresh and an ordinary column-leading refresh;
- hidden refresh with held data;
- priority among mixed page accesses;
- counter wrap.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    typedef enum logic [3:0] {
        CYC_NONE     = 4'd0,
        CYC_READ     = 4'd1,
        CYC_EARLY_WR = 4'd2,
        CYC_RMW      = 4'd3,
        CYC_ROW_RFSH = 4'd4,
        CYC_CBR      = 4'd5,
        CYC_HIDDEN   = 4'd6,
        CYC_SELF     = 4'd7,
        CYC_TEST     = 4'd8,
        CYC_INDET    = 4'd9
    } cyc_type_e;

    typedef enum logic [1:0] {
        K_ACCESS = 2'd0,
        K_CBR    = 2'd1,
        K_HIDDEN = 2'd2,
        K_TEST   = 2'd3
    } ras_kind_e;

    typedef struct packed {
        logic ras_fall;
        logic ras_rise;
        logic cas_fall;
        logic we_fall;
        logic ras_lo;
        logic cas_lo;
        logic cas_was_lo;
        logic we_lo;
        logic oe_lo;
    } strobe_ev_t;

    typedef struct packed {
        logic read;
        logic early;
        logic rmw;
        logic indet;
    } access_flags_t;

    function automatic ras_kind_e kind_at_fall(logic cas_was_lo, logic held, logic we_lo);
        if (!cas_was_lo) return K_ACCESS;
        if (held)        return K_HIDDEN;
        if (we_lo)       return K_TEST;
        return K_CBR;
    endfunction

    function automatic cyc_type_e resolve_access(access_flags_t f);
        if (f.indet) return CYC_INDET;
        if (f.rmw)   return CYC_RMW;
        if (f.early) return CYC_EARLY_WR;
        if (f.read)  return CYC_READ;
        return CYC_ROW_RFSH;
    endfunction

    function automatic cyc_type_e resolve_cycle(ras_kind_e k, access_flags_t f, logic long_low);
        case (k)
            K_ACCESS: return resolve_access(f);
            K_HIDDEN: return CYC_HIDDEN;
            K_TEST:   return CYC_TEST;
            default:  return long_low ? CYC_SELF : CYC_CBR;
        endcase
    endfunction

endpackage

// File: rtl/dcd_strobe_sampler.sv
module dcd_strobe_sampler
    import dcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       oe_n,
    output strobe_ev_t ev
);
    logic ras_q, cas_q, we_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
            we_q  <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
            we_q  <= we_n;
        end
    end

    always_comb begin
        ev.ras_fall   = ras_q & ~ras_n;
        ev.ras_rise   = ~ras_q & ras_n;
        ev.cas_fall   = cas_q & ~cas_n;
        ev.we_fall    = we_q & ~we_n;
        ev.ras_lo     = ~ras_n;
        ev.cas_lo     = ~cas_n;
        ev.cas_was_lo = ~cas_q;
        ev.we_lo      = ~we_n;
        ev.oe_lo      = ~oe_n;
    end
endmodule

// File: rtl/dcd_sat_counter.sv
module dcd_sat_counter #(
    parameter int MAX = 4,
    localparam int W  = $clog2(MAX + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         run,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAX_V = W'(MAX);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= W'(1);
        else if (run && cnt < MAX_V)
            cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/dcd_row_counter.sv
module dcd_row_counter #(
    parameter int ROW_BITS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                adv,
    output logic [ROW_BITS-1:0] row
);
    always_ff @(posedge clk) begin
        if (rst)
            row <= '0;
        else if (adv)
            row <= row + ROW_BITS'(1);
    end

    // R4: each advance moves the refresh row by exactly one, modulo the row count
    a_r4_row_step: assert property (@(posedge clk) disable iff (rst)
        adv |=> (row == $past(row) + ROW_BITS'(1)));
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
    import dcd_pkg::*;
#(
    parameter int ROW_BITS = 12,
    parameter int RMW_MIN  = 4,
    parameter int SELF_MIN = 25000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ras_n,
    input  logic                cas_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic [ROW_BITS-1:0] addr,
    output logic                cyc_valid,
    output logic [3:0]          cyc_type,
    output logic [ROW_BITS-1:0] cyc_row,
    output logic                dq_oe
);
    localparam int CW = $clog2(RMW_MIN + 1);
    localparam int RW = $clog2(SELF_MIN + 1);

    strobe_ev_t          ev;
    ras_kind_e           kind_q, kind_now;
    access_flags_t       flags_q, flags_n;
    logic                held_q, held_n;
    logic                drv_q, drv_n;
    logic [ROW_BITS-1:0] row_lat_q;
    logic [ROW_BITS-1:0] ctr_row;
    logic [CW-1:0]       cas_cnt;
    logic [RW-1:0]       ras_cnt;
    logic                in_access, acc_cas_fall, late_we, rmw_ok, long_low, ctr_adv;
    cyc_type_e           type_d;

    dcd_strobe_sampler u_sampler (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .oe_n(oe_n), .ev(ev)
    );

    dcd_sat_counter #(.MAX(RMW_MIN)) u_cas_window (
        .clk(clk), .rst(rst), .start(ev.cas_fall), .run(ev.cas_lo), .cnt(cas_cnt)
    );

    dcd_sat_counter #(.MAX(SELF_MIN)) u_ras_window (
        .clk(clk), .rst(rst), .start(ev.ras_fall), .run(ev.ras_lo), .cnt(ras_cnt)
    );

    dcd_row_counter #(.ROW_BITS(ROW_BITS)) u_refresh_row (
        .clk(clk), .rst(rst), .adv(ctr_adv), .row(ctr_row)
    );

    always_comb begin
        kind_now     = ev.ras_fall ? kind_at_fall(ev.cas_was_lo, held_q, ev.we_lo) : kind_q;
        in_access    = ev.ras_lo && (kind_now == K_ACCESS);
        acc_cas_fall = ev.cas_fall && in_access;
        late_we      = ev.we_fall && ev.cas_lo && ev.cas_was_lo && in_access;
        rmw_ok       = (cas_cnt >= CW'(RMW_MIN));
        long_low     = (ras_cnt >= RW'(SELF_MIN));

        flags_n       = ev.ras_fall ? '0 : flags_q;
        flags_n.read  = flags_n.read  | (acc_cas_fall & ~ev.we_lo);
        flags_n.early = flags_n.early | (acc_cas_fall &  ev.we_lo);
        flags_n.rmw   = flags_n.rmw   | (late_we &  rmw_ok);
        flags_n.indet = flags_n.indet | (late_we & ~rmw_ok);

        if (acc_cas_fall)    held_n = 1'b1;
        else if (!ev.cas_lo) held_n = 1'b0;
        else                 held_n = held_q;

        if (!ev.ras_lo && !ev.cas_lo)                     drv_n = 1'b0;
        else if ((acc_cas_fall && ev.we_lo) || late_we)   drv_n = 1'b0;
        else if (acc_cas_fall)                            drv_n = 1'b1;
        else                                              drv_n = drv_q;

        type_d  = resolve_cycle(kind_q, flags_q, long_low);
        ctr_adv = ev.ras_rise && (kind_q == K_CBR || kind_q == K_HIDDEN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q    <= K_ACCESS;
            flags_q   <= '0;
            held_q    <= 1'b0;
            drv_q     <= 1'b0;
            row_lat_q <= '0;
            cyc_valid <= 1'b0;
            cyc_type  <= CYC_NONE;
            cyc_row   <= '0;
            dq_oe     <= 1'b0;
        end else begin
            kind_q    <= kind_now;
            flags_q   <= flags_n;
            held_q    <= held_n;
            drv_q     <= drv_n;
            dq_oe     <= drv_n & ev.oe_lo;
            if (ev.ras_fall)
                row_lat_q <= addr;
            cyc_valid <= ev.ras_rise;
            cyc_type  <= ev.ras_rise ? type_d : CYC_NONE;
            if (ev.ras_rise)
                cyc_row <= (kind_q == K_ACCESS) ? row_lat_q : ctr_row;
        end
    end

    // R2: a report lasts a single clock
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        cyc_valid |=> !cyc_valid);

    // R2: a report only follows a sampled row-strobe rise
    a_r2_after_rise: assert property (@(posedge clk) disable iff (rst)
        cyc_valid |-> $past(ev.ras_rise));

    // R9: a test-mode entry leaves the refresh counter untouched
    a_r9_test_holds_row: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && cyc_type == CYC_TEST) |-> $stable(ctr_row));

    // R11: both strobes high releases the data pins
    a_r11_release: assert property (@(posedge clk) disable iff (rst)
        (ras_n && cas_n) |=> !dq_oe);

    // R6: an early write never leaves the data pins driven
    a_r6_early_no_drive: assert property (@(posedge clk) disable iff (rst)
        (acc_cas_fall && !we_n) |=> !dq_oe);
endmodule

// File: tb/dram_cycle_decoder_tb.sv
module dram_cycle_decoder_tb;
    localparam int RB   = 4;
    localparam int RMW  = 3;
    localparam int SELF = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
    logic [RB-1:0] addr = '0;
    logic cyc_valid, dq_oe;
    logic [3:0] cyc_type;
    logic [RB-1:0] cyc_row;

    always #2 clk = ~clk;

    dram_cycle_decoder #(.ROW_BITS(RB), .RMW_MIN(RMW), .SELF_MIN(SELF)) u_dut (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .cyc_valid(cyc_valid), .cyc_type(cyc_type),
        .cyc_row(cyc_row), .dq_oe(dq_oe)
    );

    int checks = 0, failures = 0;
    bit started = 0, done = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int n, ras_t, cas_t, kind, m_ctr, m_latch;
    bit pr, pc, pw, held, drive, f_read, f_early, f_rmw, f_indet;
    int e_valid, e_type, e_row, e_dq;

    always @(posedge clk) begin
        if (rst) begin
            n = 0; pr = 1; pc = 1; pw = 1; kind = 0; held = 0; drive = 0;
            f_read = 0; f_early = 0; f_rmw = 0; f_indet = 0;
            m_ctr = 0; m_latch = 0; e_valid = 0; e_type = 0; e_row = 0; e_dq = 0;
        end else begin
            bit r, c, w, rf, rr, cf, wf;
            n++;
            r = ras_n; c = cas_n; w = we_n;
            rf = pr && !r; rr = !pr && r; cf = pc && !c; wf = pw && !w;
            if (rf) begin
                ras_t = n; m_latch = int'(addr);
                f_read = 0; f_early = 0; f_rmw = 0; f_indet = 0;
                if (pc) kind = 0;
                else if (held) kind = 2;
                else if (!w) kind = 3;
                else kind = 1;
            end
            if (cf && !r && kind == 0) begin
                cas_t = n; held = 1;
                if (!w) begin f_early = 1; drive = 0; end
                else begin f_read = 1; drive = 1; end
            end else if (c) held = 0;
            if (wf && !c && !pc && !r && kind == 0) begin
                if (n - cas_t >= RMW) f_rmw = 1; else f_indet = 1;
                drive = 0;
            end
            if (r && c) drive = 0;
            e_valid = rr;
            e_type = 0;
            if (rr) begin
                if (kind == 0) begin
                    e_row = m_latch;
                    e_type = f_indet ? 9 : f_rmw ? 3 : f_early ? 2 : f_read ? 1 : 4;
                end else begin
                    e_row = m_ctr;
                    if (kind == 2) e_type = 6;
                    else if (kind == 3) e_type = 8;
                    else e_type = (n - ras_t >= SELF) ? 7 : 5;
                    if (kind != 3) m_ctr = (m_ctr + 1) % (1 << RB);
                end
            end
            e_dq = drive && !oe_n;
            pr = r; pc = c; pw = w;
        end
    end

    // per-clock comparison and report capture
    int last_type = -1, last_row = -1, pulses = 0;
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R2 valid", int'(cyc_valid), e_valid);
            chk("R2 type", int'(cyc_type), e_type);
            chk("R3 row", int'(cyc_row), e_row);
            chk("R11 dq_oe", int'(dq_oe), e_dq);
            if (cyc_valid) begin
                last_type = int'(cyc_type); last_row = int'(cyc_row); pulses++;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    int ras_cycles = 0;
    int cexp = 0;

    task automatic step(input int k = 1);
        repeat (k) begin @(posedge clk); #1; end
    endtask

    // mode 0 read, 1 early write, 2 write enable falls d samples after column strobe
    task automatic cas_pulse(input int mode, input int d);
        if (mode == 1) we_n = 0;
        cas_n = 0;
        if (mode == 2) begin step(d); we_n = 0; end
        step(2);
        cas_n = 1; we_n = 1;
        step(1);
    endtask

    task automatic access(input int row, input int mode, input int d);
        addr = RB'(row); ras_n = 0; ras_cycles++;
        step(2);
        cas_pulse(mode, d);
        ras_n = 1;
        step(3);
    endtask

    task automatic cbr(input int len, input bit we_low);
        cas_n = 0; we_n = we_low ? 1'b0 : 1'b1;
        step(2);
        ras_n = 0; ras_cycles++;
        step(len);
        ras_n = 1;
        step(1);
        cas_n = 1; we_n = 1;
        step(3);
    endtask

    task automatic expect_report(input string tag, input int ty, input int row);
        chk({tag, " type"}, last_type, ty);
        chk({tag, " row"}, last_row, row);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 0;
        started = 1;
        #0;
        // R1: reset state
        chk("R1 valid", int'(cyc_valid), 0);
        chk("R1 type", int'(cyc_type), 0);
        chk("R1 row", int'(cyc_row), 0);
        chk("R1 dq_oe", int'(dq_oe), 0);
        step(2);

        // R4 / R1: first column-leading refresh reports counter 0
        cbr(4, 0); expect_report("R4 first cbr", 5, 0); cexp++;

        // R3: row refresh from address bus
        addr = 4'd9; ras_n = 0; ras_cycles++; step(5); ras_n = 1; step(3);
        expect_report("R3 row refresh", 4, 9);

        // R11: read with data drive held by EDO until both strobes high
        addr = 4'd5; ras_n = 0; ras_cycles++; step(2);
        addr = 4'd2; cas_n = 0; step(3);
        chk("R11 drive during read", int'(dq_oe), 1);
        cas_n = 1; step(2);
        chk("R11 drive held after column strobe rise", int'(dq_oe), 1);
        oe_n = 1; step(2);
        chk("R11 output enable gates drive", int'(dq_oe), 0);
        oe_n = 0; ras_n = 1; step(3);
        chk("R11 release", int'(dq_oe), 0);
        expect_report("R11 read", 1, 5);

        // R6: early write, outputs stay off
        addr = 4'd6; ras_n = 0; ras_cycles++; step(2);
        we_n = 0; cas_n = 0; step(3);
        chk("R6 no drive in early write", int'(dq_oe), 0);
        cas_n = 1; we_n = 1; step(1); ras_n = 1; step(3);
        expect_report("R6 early write", 2, 6);

        // R7 / R8: boundary on the write-enable delay
        access(10, 2, RMW);     expect_report("R7 rmw at limit", 3, 10);
        access(11, 2, RMW - 1); expect_report("R8 indet below limit", 9, 11);

        // R9: test-mode entry does not advance the counter
        cbr(4, 1); expect_report("R9 test entry", 8, cexp);
        cbr(4, 0); expect_report("R9 counter held", 5, cexp); cexp++;

        // R5: hidden refresh keeps data valid and advances the counter
        addr = 4'd7; ras_n = 0; ras_cycles++; step(2);
        cas_n = 0; step(3);
        ras_n = 1; step(3);
        expect_report("R5 access before hidden", 1, 7);
        ras_n = 0; ras_cycles++; step(4);
        chk("R5 drive during hidden", int'(dq_oe), 1);
        ras_n = 1; step(2);
        chk("R5 drive after hidden", int'(dq_oe), 1);
        cas_n = 1; step(3);
        expect_report("R5 hidden", 6, cexp); cexp++;

        // R10: self refresh boundary
        cbr(SELF, 0);     expect_report("R10 self at limit", 7, cexp); cexp++;
        cbr(SELF - 1, 0); expect_report("R10 below limit", 5, cexp);   cexp++;

        // R4 tie: both strobes fall in the same sample -> access
        addr = 4'd3; ras_n = 0; cas_n = 0; ras_cycles++; step(3);
        ras_n = 1; cas_n = 1; step(3);
        expect_report("R4 same-sample tie", 1, 3);

        // R12: page priority
        addr = 4'd12; ras_n = 0; ras_cycles++; step(2);
        cas_pulse(0, 0); cas_pulse(1, 0); ras_n = 1; step(3);
        expect_report("R12 read+write", 2, 12);
        addr = 4'd13; ras_n = 0; ras_cycles++; step(2);
        cas_pulse(0, 0); cas_pulse(2, RMW); cas_pulse(1, 0); ras_n = 1; step(3);
        expect_report("R12 rmw over write", 3, 13);
        addr = 4'd14; ras_n = 0; ras_cycles++; step(2);
        cas_pulse(2, RMW); cas_pulse(2, 1); ras_n = 1; step(3);
        expect_report("R12 indet over rmw", 9, 14);

        // R4: counter wraps
        for (int i = 0; i < 16; i++) begin
            cbr(3, 0);
            expect_report("R4 wrap", 5, cexp % 16);
            cexp++;
        end

        // R2: one report per row-strobe period
        chk("R2 pulse count", pulses, ras_cycles);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule